// File: doc/BRIEF.md
# Converter Self-Calibration Sequencer

This controller runs an internal zero-scale calibration, an internal full-scale calibration, or both in a row, each time it is given a command. In each phase it sets the converter's input multiplexer to a calibration source: the channel inputs shorted together, or an internally generated full-scale voltage. It then asks for conversions through a request/valid handshake. It drops the first few results after the multiplexer change so the input can settle, and it averages the next sixteen.

The zero-scale average becomes the offset coefficient. The full-scale phase removes the current offset from its average. It then divides the ideal full-scale code by that difference in a multi-cycle restoring divider. The quotient becomes a gain coefficient in a format where 0x400000 means a gain of exactly one. Both coefficients stay in output registers that the conversion-correction path reads. A one-cycle strobe marks every update. A denominator that is not positive leaves the gain as it was and raises an error flag.

Top module: `selfcal_seq`

## Requirements
- R1: After reset, mux_sel is 00, conv_req, busy, done, fs_err, off_wr and gain_wr are low, off_coef is 0 and gain_coef is 0x400000.
- R2: While idle, cmd_valid with cmd_op 01 runs the offset phase only, 10 runs the full-scale phase only, and 11 runs the offset phase and then the full-scale phase. cmd_op 00 does nothing. busy is high from the cycle after acceptance until done.
- R3: mux_sel is 01 (inputs shorted) during the offset phase and 10 (full-scale reference) during the full-scale phase. It is 00 (normal) whenever busy is low. conv_req is high only while a phase is still collecting samples.
- R4: In each phase, the first discard_n conversions accepted after the multiplexer change are thrown away.
- R5: The offset coefficient is the sum of the next 16 accepted samples (signed, two's complement), shifted right arithmetically by 4. It is written with a one-cycle off_wr pulse.
- R6: The gain coefficient is floor(0x400000 × IDEAL_FS / (full-scale average − offset coefficient)) and is written with a one-cycle gain_wr pulse. The full-scale phase uses the offset in force when it ends, so under cmd_op 11 it uses the offset just measured.
- R7: A quotient that does not fit in 24 bits writes gain_coef as 0xFFFFFF.
- R8: If the full-scale denominator is zero or negative, gain_coef keeps its value, gain_wr stays low and fs_err goes high. fs_err stays high until the next accepted command.
- R9: At the end of a sequence, done is high for exactly one cycle, with busy low and mux_sel 00.
- R10: A command that arrives while busy is high is ignored. The running sequence neither restarts nor changes its phases.
- R11: conv_valid while conv_req is low has no effect on the coefficients or on the sample count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| cmd_valid | input | 1 | Command strobe |
| cmd_op | input | 2 | 01 offset, 10 full-scale, 11 both |
| discard_n | input | 4 | Conversions dropped after each mux change |
| mux_sel | output | 2 | 00 normal, 01 shorted inputs, 10 full-scale reference |
| conv_req | output | 1 | Requesting conversions |
| conv_valid | input | 1 | Conversion result valid |
| conv_data | input | 24 | Signed conversion result |
| off_wr | output | 1 | Offset coefficient updated |
| gain_wr | output | 1 | Gain coefficient updated |
| off_coef | output | 24 | Signed offset coefficient |
| gain_coef | output | 24 | Gain coefficient, 0x400000 is unity |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle end-of-sequence pulse |
| fs_err | output | 1 | Last full-scale denominator was not positive |

## Verification
The embedded assertions check the following on every cycle:
- the multiplexer is normal whenever the block is idle;
- requests only go out with a calibration source selected;
- done is a single cycle;
- the sample count stays bounded;
- the divider remainder stays below its divisor;
- an error never coincides with a gain update.

Only the bench scenarios can show that the arithmetic is right: the offset average, the discard count, the gain quotient and its saturation. The same holds for phase ordering under each command, use of the fresh offset, and commands or stray results being ignored.

// File: rtl/selfcal_pkg.sv
// Shared encodings for the self-calibration sequencer.
// Assumes: mux encoding is decoded by the converter front end.
package selfcal_pkg;
    typedef enum logic [1:0] {
        MUX_NORMAL = 2'b00,
        MUX_SHORT  = 2'b01,
        MUX_FSREF  = 2'b10
    } mux_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_OFF,
        ST_FS,
        ST_DIV,
        ST_FIN
    } state_e;
endpackage

// File: rtl/selfcal_avg.sv
// Averaging unit: after a start pulse it requests conversions and drops the
// first disc_n results. It sums the next 2**NLOG2 results and returns the sum
// shifted right arithmetically by NLOG2 with a one-cycle done pulse.
// Assumes: start arrives only while idle; conv_valid is counted only while
// conv_req is high.
module selfcal_avg #(
    parameter int DATA_W = 24,
    parameter int NLOG2  = 4,
    parameter int DISC_W = 4
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     start,
    input  logic [DISC_W-1:0]        disc_n,
    input  logic                     conv_valid,
    input  logic signed [DATA_W-1:0] conv_data,
    output logic                     conv_req,
    output logic                     done,
    output logic signed [DATA_W-1:0] avg
);
    localparam int ACC_W = DATA_W + NLOG2;
    localparam int NSAMP = 1 << NLOG2;

    logic                    active;
    logic [DISC_W-1:0]       disc;
    logic [NLOG2:0]          n;
    logic signed [ACC_W-1:0] acc;
    logic signed [ACC_W-1:0] samp_ext;
    logic signed [ACC_W-1:0] sum_next;
    logic signed [ACC_W-1:0] sum_sh;

    // Sign-extend the sample and form the running sum and its shifted mean.
    always_comb begin
        samp_ext = {{NLOG2{conv_data[DATA_W-1]}}, conv_data};
        sum_next = acc + samp_ext;
        sum_sh   = sum_next >>> NLOG2;
    end

    assign conv_req = active;

    // Discard, accumulate and finish control.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active <= 1'b0;
            disc   <= '0;
            n      <= '0;
            acc    <= '0;
            done   <= 1'b0;
            avg    <= '0;
        end else begin
            done <= 1'b0;
            if (start) begin
                active <= 1'b1;
                disc   <= disc_n;
                n      <= '0;
                acc    <= '0;
            end else if (active && conv_valid) begin
                if (disc != '0) begin
                    disc <= disc - 1'b1;
                end else begin
                    acc <= sum_next;
                    n   <= n + 1'b1;
                    if (n == (NLOG2+1)'(NSAMP - 1)) begin
                        active <= 1'b0;
                        done   <= 1'b1;
                        avg    <= sum_sh[DATA_W-1:0];
                    end
                end
            end
        end
    end

    // R5: the sample count never runs past the averaging window.
    a_r5_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
        n <= (NLOG2+1)'(NSAMP));
    // R5: done only follows an active collection.
    a_r5_done_after_active: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !active && $past(active));
endmodule

// File: rtl/selfcal_div.sv
// Restoring divider, one quotient bit per cycle, NUM_W cycles per divide.
// Assumes: den is nonzero at start (the caller screens it); start arrives
// only while the previous divide is finished.
module selfcal_div #(
    parameter int NUM_W = 46,
    parameter int DEN_W = 25
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [NUM_W-1:0] num,
    input  logic [DEN_W-1:0] den,
    output logic             done,
    output logic [NUM_W-1:0] quo
);
    localparam int CW = $clog2(NUM_W + 1);

    logic             run;
    logic [CW-1:0]    cnt;
    logic [NUM_W-1:0] nsh;
    logic [DEN_W-1:0] dq;
    logic [DEN_W-1:0] rem;
    logic [DEN_W:0]   trial;
    logic [DEN_W:0]   diff;
    logic             ge;

    // Trial subtraction for the next quotient bit.
    always_comb begin
        trial = {rem, nsh[NUM_W-1]};
        diff  = trial - {1'b0, dq};
        ge    = trial >= {1'b0, dq};
    end

    // Iteration control and remainder/quotient update.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run  <= 1'b0;
            cnt  <= '0;
            nsh  <= '0;
            dq   <= '0;
            rem  <= '0;
            quo  <= '0;
            done <= 1'b0;
        end else begin
            done <= 1'b0;
            if (start) begin
                run <= 1'b1;
                cnt <= CW'(NUM_W);
                nsh <= num;
                dq  <= den;
                rem <= '0;
                quo <= '0;
            end else if (run) begin
                rem <= ge ? diff[DEN_W-1:0] : trial[DEN_W-1:0];
                quo <= {quo[NUM_W-2:0], ge};
                nsh <= nsh << 1;
                cnt <= cnt - 1'b1;
                if (cnt == CW'(1)) begin
                    run  <= 1'b0;
                    done <= 1'b1;
                end
            end
        end
    end

    // R6: the partial remainder stays below the divisor during a divide.
    a_r6_rem_below_den: assert property (@(posedge clk) disable iff (!rst_n)
        run |-> rem < dq);
    // R6: the caller never starts a divide by zero.
    a_r6_den_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
        start |-> den != '0);
endmodule

// File: rtl/selfcal_seq.sv
// Self-calibration sequencer top. It decodes a command, steps the input
// multiplexer through the offset and full-scale phases, and uses one
// averaging unit for both phases. It screens the full-scale denominator,
// runs the gain divide, and publishes the coefficients with write strobes.
// Assumes: the converter honours mux_sel for conversions requested after it
// changes, and conv_data is two's complement.
module selfcal_seq
    import selfcal_pkg::*;
#(
    parameter int DATA_W     = 24,
    parameter int NLOG2      = 4,
    parameter int DISC_W     = 4,
    parameter int UNITY_LOG2 = 22,
    parameter int IDEAL_FS   = 8388607
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     cmd_valid,
    input  logic [1:0]               cmd_op,
    input  logic [DISC_W-1:0]        discard_n,
    output logic [1:0]               mux_sel,
    output logic                     conv_req,
    input  logic                     conv_valid,
    input  logic signed [DATA_W-1:0] conv_data,
    output logic                     off_wr,
    output logic                     gain_wr,
    output logic signed [DATA_W-1:0] off_coef,
    output logic [DATA_W-1:0]        gain_coef,
    output logic                     busy,
    output logic                     done,
    output logic                     fs_err
);
    localparam int NUM_W = DATA_W + UNITY_LOG2;
    localparam int DEN_W = DATA_W + 1;
    localparam logic [NUM_W-1:0] NUMER = NUM_W'(IDEAL_FS) << UNITY_LOG2;
    localparam logic [DATA_W-1:0] UNITY = DATA_W'(1) << UNITY_LOG2;

    state_e                   state;
    mux_e                     mux;
    logic                     fs_after;
    logic                     av_start;
    logic                     av_done;
    logic signed [DATA_W-1:0] av_avg;
    logic                     div_start;
    logic                     div_done;
    logic [NUM_W-1:0]         div_quo;
    logic [DEN_W-1:0]         den_q;
    logic signed [DATA_W:0]   den_s;
    logic                     den_pos;
    logic [DATA_W-1:0]        gain_sat;

    // Shared averaging unit for both calibration phases.
    selfcal_avg #(
        .DATA_W(DATA_W), .NLOG2(NLOG2), .DISC_W(DISC_W)
    ) u_avg (
        .clk(clk), .rst_n(rst_n), .start(av_start), .disc_n(discard_n),
        .conv_valid(conv_valid), .conv_data(conv_data),
        .conv_req(conv_req), .done(av_done), .avg(av_avg)
    );

    // Gain divider.
    selfcal_div #(
        .NUM_W(NUM_W), .DEN_W(DEN_W)
    ) u_div (
        .clk(clk), .rst_n(rst_n), .start(div_start), .num(NUMER),
        .den(den_q), .done(div_done), .quo(div_quo)
    );

    // Full-scale denominator and its positivity test; gain saturation.
    always_comb begin
        den_s    = {av_avg[DATA_W-1], av_avg} - {off_coef[DATA_W-1], off_coef};
        den_pos  = !den_s[DATA_W] && (den_s != '0);
        gain_sat = (div_quo[NUM_W-1:DATA_W] != '0) ? '1 : div_quo[DATA_W-1:0];
    end

    assign busy    = (state != ST_IDLE);
    assign mux_sel = mux;

    // Sequencer: phase stepping, coefficient registers and strobes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= ST_IDLE;
            mux       <= MUX_NORMAL;
            fs_after  <= 1'b0;
            av_start  <= 1'b0;
            div_start <= 1'b0;
            den_q     <= '0;
            off_coef  <= '0;
            gain_coef <= UNITY;
            off_wr    <= 1'b0;
            gain_wr   <= 1'b0;
            done      <= 1'b0;
            fs_err    <= 1'b0;
        end else begin
            av_start  <= 1'b0;
            div_start <= 1'b0;
            off_wr    <= 1'b0;
            gain_wr   <= 1'b0;
            done      <= 1'b0;
            case (state)
                ST_IDLE: begin
                    if (cmd_valid && cmd_op != 2'b00) begin
                        fs_after <= cmd_op[1];
                        fs_err   <= 1'b0;
                        av_start <= 1'b1;
                        if (cmd_op[0]) begin
                            state <= ST_OFF;
                            mux   <= MUX_SHORT;
                        end else begin
                            state <= ST_FS;
                            mux   <= MUX_FSREF;
                        end
                    end
                end
                ST_OFF: begin
                    if (av_done) begin
                        off_coef <= av_avg;
                        off_wr   <= 1'b1;
                        if (fs_after) begin
                            state    <= ST_FS;
                            mux      <= MUX_FSREF;
                            av_start <= 1'b1;
                        end else begin
                            state <= ST_FIN;
                            mux   <= MUX_NORMAL;
                        end
                    end
                end
                ST_FS: begin
                    if (av_done) begin
                        mux <= MUX_NORMAL;
                        if (den_pos) begin
                            den_q     <= den_s[DEN_W-1:0];
                            div_start <= 1'b1;
                            state     <= ST_DIV;
                        end else begin
                            fs_err <= 1'b1;
                            state  <= ST_FIN;
                        end
                    end
                end
                ST_DIV: begin
                    if (div_done) begin
                        gain_coef <= gain_sat;
                        gain_wr   <= 1'b1;
                        state     <= ST_FIN;
                    end
                end
                default: begin
                    done  <= 1'b1;
                    state <= ST_IDLE;
                end
            endcase
        end
    end

    // R3: the multiplexer is normal whenever no sequence runs.
    a_r3_idle_mux_normal: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> mux_sel == MUX_NORMAL);
    // R3: conversions are requested only with a calibration source selected.
    a_r3_req_with_source: assert property (@(posedge clk) disable iff (!rst_n)
        conv_req |-> mux_sel != MUX_NORMAL);
    // R9: done lasts one cycle and is never raised while busy.
    a_r9_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    a_r9_done_not_busy: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);
    // R8: an error never comes with a gain update or a gain change.
    a_r8_err_keeps_gain: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(fs_err) |-> !gain_wr && $stable(gain_coef));
    // R10: a command seen while busy leaves the phase plan alone.
    a_r10_busy_ignores_cmd: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && cmd_valid) |=> $stable(fs_after));
endmodule

// File: tb/sim_selfcal_seq.sv
// Bench: a behavioural converter and a reference model of expected
// coefficients, with relations between outputs checked on every clock.
module sim_selfcal_seq;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmd_valid = 1'b0;
    logic [1:0]  cmd_op = 2'b00;
    logic [3:0]  discard_n = 4'd1;
    logic [1:0]  mux_sel;
    logic        conv_req;
    logic        conv_valid = 1'b0;
    logic [23:0] conv_data = '0;
    logic        off_wr, gain_wr, busy, done, fs_err;
    logic [23:0] off_coef, gain_coef;

    int errors = 0;
    int checks = 0;
    int bs = 0, bf = 0, dsc = 1;
    int ks = 0, kf = 0, gap = 0;
    int off_wr_cnt = 0, gain_wr_cnt = 0, done_cnt = 0, busy_cnt = 0;
    bit stray = 1'b0;
    int m_off = 0;
    longint m_gain = 64'h400000;

    always #2 clk = ~clk;

    selfcal_seq u0 (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
        .discard_n(discard_n), .mux_sel(mux_sel), .conv_req(conv_req),
        .conv_valid(conv_valid), .conv_data(conv_data), .off_wr(off_wr),
        .gain_wr(gain_wr), .off_coef(off_coef), .gain_coef(gain_coef),
        .busy(busy), .done(done), .fs_err(fs_err)
    );

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int gen(input int base, input int k);
        if (k < dsc) return base + 40000 - 17 * k;
        return base + ((k * 7) % 11) - 5;
    endfunction

    function automatic int exp_avg(input int base);
        longint s = 0;
        for (int k = dsc; k < dsc + 16; k++) s += longint'(gen(base, k));
        return int'(s >>> 4);
    endfunction

    function automatic longint exp_gain(input longint den);
        longint q = (longint'(8388607) <<< 22) / den;
        return (q > 64'hFFFFFF) ? 64'hFFFFFF : q;
    endfunction

    // Converter model: answers requests, skipping every third cycle.
    always @(negedge clk) begin
        conv_valid = 1'b0;
        gap = (gap + 1) % 3;
        if (conv_req && gap != 2) begin
            conv_valid = 1'b1;
            if (mux_sel == 2'b01) begin conv_data = 24'(gen(bs, ks)); ks++; end
            else begin conv_data = 24'(gen(bf, kf)); kf++; end
        end else if (stray) begin
            conv_valid = 1'b1;
            conv_data = 24'h123456;
        end
    end

    // Per-clock monitor: output relations and event counts.
    always @(negedge clk) begin
        if (rst_n) begin
            if (off_wr) off_wr_cnt++;
            if (gain_wr) gain_wr_cnt++;
            if (done) done_cnt++;
            if (busy) busy_cnt++;
            if (!busy) chk(mux_sel == 2'b00 && !conv_req, "R3 idle mux/req", mux_sel, 0);
            if (conv_req) chk(busy, "R3 req only when busy", busy, 1);
            if (done) chk(!busy && mux_sel == 2'b00, "R9 done state", busy, 0);
        end
    end

    task automatic issue(input logic [1:0] op);
        @(negedge clk);
        cmd_op = op;
        cmd_valid = 1'b1;
        @(negedge clk);
        cmd_valid = 1'b0;
    endtask

    task automatic clear_counts();
        ks = 0; kf = 0; off_wr_cnt = 0; gain_wr_cnt = 0; done_cnt = 0; busy_cnt = 0;
    endtask

    task automatic wait_done();
        int n = 0;
        while (!done && n < 3000) begin @(negedge clk); n++; end
        chk(n < 3000, "R9 watchdog", n, 3000);
        @(negedge clk);
        chk(done_cnt == 1 && !done, "R9 single done", done_cnt, 1);
    endtask

    task automatic check_coefs(input string tag);
        chk($signed(off_coef) == m_off, {tag, " offset"}, $signed(off_coef), m_off);
        chk(longint'(gain_coef) == m_gain, {tag, " gain"}, gain_coef, m_gain);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state.
        chk(mux_sel == 0 && !busy && !done && !fs_err && !conv_req && !off_wr && !gain_wr,
            "R1 reset flags", {mux_sel, busy, done, fs_err}, 0);
        chk(off_coef == 0 && gain_coef == 24'h400000, "R1 reset coefs", gain_coef, 64'h400000);
        rst_n = 1'b1;

        // R11: stray results while idle are ignored.
        stray = 1'b1;
        repeat (4) @(negedge clk);
        stray = 1'b0;
        @(negedge clk);
        chk(off_wr_cnt == 0 && off_coef == 0, "R11 stray ignored", off_wr_cnt, 0);

        // R2 R4 R5 R6: both phases, one discard, fresh offset used.
        clear_counts(); dsc = 1; discard_n = 4'd1; bs = 1200; bf = 24'h700000;
        issue(2'b11);
        wait_done();
        m_off = exp_avg(bs);
        m_gain = exp_gain(longint'(exp_avg(bf)) - m_off);
        check_coefs("R6 both");
        chk(off_wr_cnt == 1 && gain_wr_cnt == 1, "R2 both strobes", gain_wr_cnt, 1);
        chk(ks == 17 && kf == 17, "R4 discard one", kf, 17);
        chk(!fs_err, "R8 no error", fs_err, 0);

        // R5: offset only, negative offset, no discard; gain untouched.
        clear_counts(); dsc = 0; discard_n = 4'd0; bs = -3000;
        issue(2'b01);
        wait_done();
        m_off = exp_avg(bs);
        check_coefs("R5 offset only");
        chk(gain_wr_cnt == 0 && kf == 0 && ks == 16, "R2 offset only phases", kf, 0);

        // R6 R4: full-scale only with three discards uses the stored offset.
        clear_counts(); dsc = 3; discard_n = 4'd3; bf = 24'h5A0000;
        issue(2'b10);
        wait_done();
        m_gain = exp_gain(longint'(exp_avg(bf)) - m_off);
        check_coefs("R6 fs only");
        chk(off_wr_cnt == 0 && ks == 0 && kf == 19, "R4 discard three", kf, 19);

        // R10: command while busy is ignored.
        clear_counts(); dsc = 1; discard_n = 4'd1; bs = 500;
        issue(2'b01);
        repeat (10) @(negedge clk);
        issue(2'b11);
        wait_done();
        m_off = exp_avg(bs);
        check_coefs("R10 busy cmd");
        chk(off_wr_cnt == 1 && gain_wr_cnt == 0 && kf == 0, "R10 no extra phase", kf, 0);
        repeat (5) @(negedge clk);
        chk(!busy, "R10 no restart", busy, 0);

        // R8: non-positive denominator keeps the gain and flags an error.
        clear_counts(); bf = m_off - 1000;
        issue(2'b10);
        wait_done();
        check_coefs("R8 err keeps gain");
        chk(fs_err && gain_wr_cnt == 0, "R8 error flag", fs_err, 1);

        // R7 R8: tiny denominator saturates; the new command clears fs_err.
        clear_counts(); bf = m_off + 100;
        issue(2'b10);
        wait_done();
        m_gain = 64'hFFFFFF;
        check_coefs("R7 saturate");
        chk(!fs_err && gain_wr_cnt == 1, "R8 error cleared", fs_err, 0);

        // R2: op 00 does nothing.
        clear_counts();
        issue(2'b00);
        repeat (10) @(negedge clk);
        chk(busy_cnt == 0 && done_cnt == 0, "R2 op zero ignored", busy_cnt, 0);
        check_coefs("R2 op zero");

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule